// File: doc/BRIEF.md
# Product-Data EEPROM Window

This block is a configuration-space capability that gives the host word-wide access to a small serial EEPROM holding board identity data. The host sees two 32-bit words. The header word carries a fixed capability ID, a next-capability pointer, a longword-aligned byte address and a completion flag. The data word holds the four bytes that are moved to or from the EEPROM.

The host starts a transfer by writing the address together with the flag. The value of the flag chosen in that write sets the direction of the transfer. A flag of 1 stores the data word into the EEPROM, and the hardware clears the flag when the store is done. A flag of 0 fetches four bytes into the data word, and the hardware sets the flag once all four have arrived. The engine drives the EEPROM side through a byte-wide request/acknowledge port. That port is served by a separate serial controller, which is not part of this block.

Top module: `prod_data_win`

## Requirements
- R1: After reset the header word reads 32'h0000_0003, the data word reads 0, and `ee_req` is low.
- R2: The header word is laid out as follows. Bits 7:0 hold the ID 03h. Bits 15:8 hold the next pointer (default 0), and bits 9:8 always read 0. Bits 24:18 hold the stored word address. Bits 17:16 and 30:25 read 0. Bit 31 holds the completion flag.
- R3: An idle-time header write (`reg_sel`=0) with byte lanes 3 and 2 both enabled and bit 31 = 1 stores the data word to the EEPROM. Bit 31 reads 1 until the fourth byte is acknowledged, and 0 after that.
- R4: The same write with bit 31 = 0 fetches four EEPROM bytes. Bit 31 reads 0 until the fourth byte is acknowledged, and 1 after that, with the data word then holding the fetched bytes.
- R5: Data lane k (bits 8k+7:8k) pairs with byte address base+k. Bytes go out in ascending order, one request at a time. `ee_addr` holds steady until its acknowledge, and each transfer makes exactly four requests.
- R6: Header writes made while a transfer is running change neither the address nor the flag, and they start no new transfer.
- R7: A data-word write (`reg_sel`=1) made while idle updates only the byte lanes whose `reg_be` bit is set. A data-word write made during a transfer is ignored.
- R8: After a store, the data word still holds the value that was stored. The data word changes only through lane writes made while idle, or through a fetch.
- R9: A header write that does not enable both byte lanes 3 and 2 is ignored. Neither the flag nor the address changes, and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 = header word, 1 = data word |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| ee_req | output | 1 | Byte transfer request |
| ee_we | output | 1 | 1 = store byte, 0 = fetch byte |
| ee_addr | output | ADDR_W | EEPROM byte address |
| ee_wdata | output | 8 | Byte to store |
| ee_ack | input | 1 | One-cycle acknowledge of the current byte |
| ee_rdata | input | 8 | Fetched byte, valid with `ee_ack` |

## Verification
Stores and fetches are issued in random order, to random aligned addresses, with random data, and the EEPROM model acknowledges after a random delay. This shows whether the direction really follows the written flag and whether the flag's polarity flips correctly, and a varying acknowledge latency exposes any address that moves before its acknowledge. Fetching back a word that was just stored shows the byte-lane-to-address pairing. A write to a fixed word followed by a read of the neighbouring word shows whether the sequence starts at the right byte. Directed cases write the header during a transfer, write the header with only partial lanes, and make lane-masked data writes both idle and busy. These cases separate a correct block from one that ignores the busy or lane guards.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 2;

  typedef enum logic {ST_IDLE, ST_XFER} pdw_state_e;

  // Header word: flag | zero | address field (aligned) | next ptr | id
  function automatic logic [31:0] pack_header(
    input logic [7:0]  cap_id,
    input logic [7:0]  next_ptr,
    input logic [14:0] addr_field,
    input logic        flag
  );
    logic [31:0] w;
    w        = '0;
    w[7:0]   = cap_id;
    w[15:8]  = {next_ptr[7:2], 2'b00};
    w[30:16] = {6'b0, addr_field[8:2], 2'b00};
    w[31]    = flag;
    return w;
  endfunction

  // Byte address of lane k of a word at word index waddr
  function automatic logic [15:0] lane_addr(input logic [13:0] waddr,
                                            input logic [LANE_W-1:0] lane);
    return {waddr, lane};
  endfunction

  function automatic logic [7:0] lane_byte(input logic [31:0] word,
                                           input logic [LANE_W-1:0] lane);
    return word[8*lane +: 8];
  endfunction
endpackage

// File: rtl/pdw_seq.sv
module pdw_seq
  import pdw_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned WA_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_store,
  input  logic [WA_W-1:0]   waddr,
  input  logic              ee_ack,
  output logic              busy,
  output logic              dir_store,
  output logic              done,
  output logic              cap_en,
  output logic [LANE_W-1:0] lane,
  output logic [ADDR_W-1:0] ee_addr
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

  pdw_state_e st_q;
  logic [LANE_W-1:0] lane_q;
  logic dir_q;
  logic [15:0] full_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lane_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_XFER;
          lane_q <= '0;
          dir_q  <= start_store;
        end
        default: if (ee_ack) begin
          lane_q <= lane_q + 1'b1;
          if (lane_q == LAST) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy      = (st_q == ST_XFER);
  assign dir_store = dir_q;
  assign lane      = lane_q;
  assign done      = busy && ee_ack && (lane_q == LAST);
  assign cap_en    = busy && ee_ack && !dir_q;
  assign full_addr = lane_addr(14'(waddr), lane_q);
  assign ee_addr   = full_addr[ADDR_W-1:0];
endmodule

// File: rtl/pdw_regs.sv
module pdw_regs
  import pdw_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned WA_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  input  logic              data_wr,
  input  logic              busy,
  input  logic              done,
  input  logic              cap_en,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        cap_byte,
  output logic [WA_W-1:0]   waddr,
  output logic              flag,
  output logic [31:0]       data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr <= '0;
      flag  <= 1'b0;
    end else if (start) begin
      waddr <= wdata[16+ADDR_W-1:18];
      flag  <= wdata[31];
    end else if (done) begin
      flag  <= ~flag;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        data_q[8*k +: 8] <= '0;
      else if (cap_en && lane == LANE_W'(k))
        data_q[8*k +: 8] <= cap_byte;
      else if (data_wr && !busy && be[k])
        data_q[8*k +: 8] <= wdata[8*k +: 8];
    end
  end
endmodule

// File: rtl/prod_data_win.sv
module prod_data_win
  import pdw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter logic [7:0]  CAP_ID   = 8'h03,
  parameter logic [7:0]  NEXT_PTR = 8'h00,
  localparam int unsigned WA_W    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ee_req,
  output logic              ee_we,
  output logic [ADDR_W-1:0] ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic              ee_ack,
  input  logic [7:0]        ee_rdata
);
  logic              busy, dir_store, done, cap_en, flag, start, data_wr, hdr_wr;
  logic [LANE_W-1:0] lane;
  logic [WA_W-1:0]   waddr;
  logic [31:0]       data_q, hdr_word;

  assign hdr_wr  = reg_wr && !reg_sel;
  assign data_wr = reg_wr && reg_sel;
  assign start   = hdr_wr && (reg_be[3:2] == 2'b11) && !busy;

  pdw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .start, .start_store(reg_wdata[31]), .waddr, .ee_ack,
    .busy, .dir_store, .done, .cap_en, .lane, .ee_addr
  );

  pdw_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .start, .wdata(reg_wdata), .be(reg_be), .data_wr, .busy,
    .done, .cap_en, .lane, .cap_byte(ee_rdata), .waddr, .flag, .data_q
  );

  assign hdr_word  = pack_header(CAP_ID, NEXT_PTR,
                                 15'({waddr, 2'b00}), flag);
  assign reg_rdata = reg_sel ? data_q : hdr_word;
  assign ee_req    = busy;
  assign ee_we     = busy && dir_store;
  assign ee_wdata  = lane_byte(data_q, lane);
endmodule

// File: rtl/pdw_chk.sv
module pdw_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ee_req,
  input logic              ee_ack,
  input logic [ADDR_W-1:0] ee_addr,
  input logic              done,
  input logic              dir_store,
  input logic              flag,
  input logic              start,
  input logic [31:0]       data_q
);
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> ee_req && $stable(ee_addr)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_ack && !done |=> ee_addr == ADDR_W'($past(ee_addr) + 1'b1)); // R5
  AST_STORE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && dir_store |=> !flag); // R3
  AST_FETCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && !dir_store |=> flag); // R4
  AST_BUSY_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && $stable(flag)); // R6
  AST_STORE_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dir_store |=> $stable(data_q)); // R8
  AST_IDLE_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(flag)); // R9
endmodule

bind prod_data_win pdw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ee_req(ee_req), .ee_ack(ee_ack),
  .ee_addr(ee_addr), .done(done), .dir_store(dir_store), .flag(flag),
  .start(start), .data_q(data_q)
);

// File: tb/sim_prod_data_win.sv
`timescale 1ns/1ps
module sim_prod_data_win;
  localparam int AW = 9;
  localparam int MB = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [3:0] reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ee_req, ee_we, ee_ack;
  logic [AW-1:0] ee_addr;
  logic [7:0] ee_wdata, ee_rdata;

  always #2 clk = ~clk;

  prod_data_win u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] mem [MB];
  logic [7:0] sh  [MB];
  int mb = 0, op_base = 0, addr_err = 0;
  logic [1:0] dly = 0;

  // behavioural byte memory
  always @(posedge clk) begin
    if (!rst_n) begin
      ee_ack <= 0; ee_rdata <= 0;
    end else begin
      ee_ack <= 0;
      if (ee_req && !ee_ack) begin
        if (dly == 0) begin
          ee_ack <= 1;
          ee_rdata <= mem[ee_addr];
          if (ee_we) mem[ee_addr] <= ee_wdata;
          if (int'(ee_addr) != op_base + mb) addr_err++;
          mb = mb + 1;
          dly <= 2'($urandom % 3);
        end else dly <= dly - 1;
      end
    end
  end

  function automatic logic [31:0] exp_hdr(input int a, input logic f);
    return {f, 6'b0, 7'(a >> 2), 2'b00, 8'h00, 8'h03};
  endfunction
  function automatic logic [31:0] sh_word(input int a);
    return {sh[a+3], sh[a+2], sh[a+1], sh[a]};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_be = be; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_be = 0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel; #0.5; d = reg_rdata;
  endtask

  task automatic wait_flag(input logic f);
    logic [31:0] h;
    for (int i = 0; i < 200; i++) begin
      rd(0, h);
      if (h[31] == f && !ee_req) return;
      @(negedge clk);
    end
    chk("R3/R4 timeout", h, {f, 31'b0});
  endtask

  task automatic op(input logic store, input int a, input logic [31:0] d);
    logic [31:0] h, dv;
    if (store) wr(1, 4'hF, d);
    mb = 0; op_base = a; addr_err = 0;
    wr(0, 4'b1100, {store, 6'b0, 7'(a >> 2), 2'b00, 16'h0});
    wait_flag(!store);
    rd(0, h);
    chk(store ? "R3 flag after store" : "R4 flag after fetch", h, exp_hdr(a, !store));
    chk("R5 request count", 32'(mb), 32'd4);
    chk("R5 ascending addresses", 32'(addr_err), 0);
    rd(1, dv);
    if (store) begin
      for (int k = 0; k < 4; k++) sh[a+k] = d[8*k +: 8];
      chk("R5 stored lane order", {mem[a+3], mem[a+2], mem[a+1], mem[a]}, sh_word(a));
      chk("R8 data kept after store", dv, d);
    end else
      chk("R4 fetched word", dv, sh_word(a));
  endtask

  initial begin
    logic [31:0] v, h;
    void'($urandom(32'h5EED));
    for (int i = 0; i < MB; i++) begin
      mem[i] = 8'(i * 7 + 3); sh[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); chk("R1 header reset", v, 32'h0000_0003);
    rd(1, v); chk("R1 data reset", v, 0);
    chk("R1 no request", 32'(ee_req), 0);

    // R7 lane writes while idle
    wr(1, 4'hF, 32'h1122_3344);
    wr(1, 4'b0101, 32'hAABB_CCDD);
    rd(1, v); chk("R7 lane-masked write", v, 32'h11BB_33DD);

    // R9 partial-lane header write
    wr(0, 4'b1000, 32'h8004_0000);
    repeat (3) @(negedge clk);
    rd(0, v); chk("R9 partial header ignored", v, 32'h0000_0003);
    chk("R9 no request", 32'(ee_req), 0);

    // directed store/fetch, neighbour words, top of space
    op(1, 8, 32'hDEAD_BEEF);
    op(0, 12, 0);
    op(0, 8, 0);
    op(1, MB - 4, 32'h0102_0304);
    op(0, MB - 4, 0);
    // R2 ignored high address bits and aligned low bits
    mb = 0; op_base = 16; addr_err = 0;
    wr(0, 4'b1100, 32'h7E13_0000);
    wait_flag(1);
    rd(0, v); chk("R2 field masking", v, exp_hdr(16, 1));

    // R6 header write during fetch
    mb = 0; op_base = 20; addr_err = 0;
    wr(0, 4'b1100, {1'b0, 6'b0, 7'(20 >> 2), 18'h0});
    wr(0, 4'b1100, {1'b1, 6'b0, 7'(40 >> 2), 18'h0});
    wait_flag(1);
    rd(0, h); chk("R6 header write ignored while busy", h, exp_hdr(20, 1));
    rd(1, v); chk("R6 fetched word unaffected", v, sh_word(20));
    chk("R6 no second transfer", 32'(mb), 4);

    // R7 data write during store ignored
    wr(1, 4'hF, 32'h5555_AAAA);
    mb = 0; op_base = 24; addr_err = 0;
    wr(0, 4'b1100, {1'b1, 6'b0, 7'(24 >> 2), 18'h0});
    wr(1, 4'hF, 32'hFFFF_FFFF);
    wait_flag(0);
    for (int k = 0; k < 4; k++) sh[24+k] = 8'(32'h5555_AAAA >> (8*k));
    rd(1, v); chk("R7 busy data write ignored", v, 32'h5555_AAAA);
    chk("R7 stored value", {mem[27], mem[26], mem[25], mem[24]}, sh_word(24));

    // random mix
    for (int n = 0; n < 40; n++) begin
      int a;
      a = int'($urandom % (MB / 4)) * 4;
      op(1'($urandom % 2), a, $urandom);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule